// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge with Error Translation

This block sits between an AXI4-Lite requester and a group of APB peripherals. It takes one AXI4-Lite read or write at a time and runs it on the APB side as a two-phase transfer. The first cycle is SETUP, with select high and enable low. Every following cycle is ACCESS, with enable high, until the peripheral raises its ready. In the cycle that completes the transfer, the bridge samples the peripheral's error line. It turns that value into an AXI response code and returns the code on the response channel of the same transaction: B for a write, R for a read.

Addresses are decoded inside the bridge against a parameterized table of base/size windows. Each window owns one APB select line. An address that falls in no window is answered at once with a decode error, and no APB transfer is started for it. A parameter picks what a failed read returns on its data bus. One option passes the peripheral's read data through. The other forces a fixed poison word.

Top module: `axil_apb_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, BVALID, RVALID, every select line and PENABLE are low.
- R2: A transaction whose address lies in a window drives only that window's select line (at most one select line is high at any time). Its first APB cycle has PENABLE low, and every later cycle has PENABLE high. PADDR equals the AXI address, PWRITE is 1 for a write, and PWDATA carries the write data.
- R3: A transfer that completes with the peripheral error line low returns response code 2'b00 (OKAY).
- R4: A transfer that completes with the peripheral error line high returns 2'b10 (SLVERR): on BRESP for a write, on RRESP for a read.
- R5: The error line and read data are sampled only in an ACCESS cycle where PREADY is high. Wait states (ACCESS cycles with PREADY low) extend the transfer with address and select held. The error value and read data shown in those cycles do not change the result.
- R6: An address in no window returns 2'b11 (DECERR), and no select line rises for that transaction. A decode miss takes priority over the peripheral error when the code is chosen.
- R7: BVALID/RVALID rise only after APB completion or a decode miss. They stay high, with code and data unchanged, until BREADY/RREADY is seen.
- R8: If a write (AWVALID and WVALID both high) and a read (ARVALID high) are pending in the same cycle, the write is accepted first. The read is accepted after the write's response handshake.
- R9: A read answered OKAY returns PRDATA. With the poison option on (the default), a read answered SLVERR or DECERR returns the poison word (default 32'hDEAD_BEEF). With the option off, an SLVERR read passes PRDATA through.
- R10: Only one transaction is in flight. AWREADY and ARREADY stay low from acceptance until the response handshake, and BVALID and RVALID are never high together.
- R11: A write is accepted only when AW and W are both valid, and AWREADY and WREADY rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response taken |
| m_psel | output | N_SLOTS | One select line per address window |
| m_penable | output | 1 | APB enable (ACCESS phase) |
| m_paddr | output | ADDR_W | APB address |
| m_pwrite | output | 1 | APB direction, 1 = write |
| m_pwdata | output | DATA_W | APB write data |
| m_prdata | input | DATA_W | APB read data |
| m_pready | input | 1 | APB transfer complete |
| m_pslverr | input | 1 | APB error verdict |

## Verification
Some properties are checked on every cycle. These cover the select/enable sequencing and holds across wait states. They also tie a completing APB cycle to the code on the next response, and check that the response is held until taken, that at most one transaction is in flight, and that writes win arbitration. Other behaviours can only be shown by the bench scenarios. Decode misses must raise no select line, window boundaries must fall on the correct side, and miss must win over a peripheral error. The read-data policy on error, and the fact that garbage shown on the error line during wait states is ignored, are also shown there. In each case the bench follows one transaction from its AXI request to its response.

// File: rtl/axil_apb_pkg.sv
package axil_apb_pkg;

    localparam logic [1:0] RSP_OKAY   = 2'b00;
    localparam logic [1:0] RSP_SLVERR = 2'b10;
    localparam logic [1:0] RSP_DECERR = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic       wr;
        logic [1:0] code;
    } txn_tag_t;

    function automatic logic [1:0] pick_resp(input logic miss, input logic slv_err);
        if (miss)
            return RSP_DECERR;
        else if (slv_err)
            return RSP_SLVERR;
        else
            return RSP_OKAY;
    endfunction

endpackage

// File: rtl/axil_apb_decode.sv
module axil_apb_decode #(
    parameter int ADDR_W  = 32,
    parameter int N_SLOTS = 4,
    parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BASE = '0,
    parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_SIZE = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_SLOTS-1:0] hit,
    output logic               miss
);
    localparam int CW = ADDR_W + 1;

    logic [N_SLOTS-1:0] raw;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_win
        logic [CW-1:0] lo, hi, a;
        assign lo = {1'b0, SLOT_BASE[g*ADDR_W +: ADDR_W]};
        assign hi = lo + {1'b0, SLOT_SIZE[g*ADDR_W +: ADDR_W]};
        assign a  = {1'b0, addr};
        assign raw[g] = (a >= lo) && (a < hi);
    end

    // lowest window wins if two overlap, keeping the select one-hot
    always_comb begin
        logic found;
        found = 1'b0;
        hit   = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (raw[i] && !found) begin
                hit[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign miss = ~|raw;
endmodule

// File: rtl/axil_apb_arb.sv
module axil_apb_arb (
    input  logic idle,
    input  logic awvalid,
    input  logic wvalid,
    input  logic arvalid,
    output logic take_wr,
    output logic take_rd
);
    logic wr_pending;

    assign wr_pending = awvalid && wvalid;
    assign take_wr    = idle && wr_pending;
    assign take_rd    = idle && arvalid && !wr_pending;
endmodule

// File: rtl/axil_apb_seq.sv
module axil_apb_seq
    import axil_apb_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          N_SLOTS    = 4,
    parameter bit          POISON_EN  = 1'b1,
    parameter logic [DATA_W-1:0] POISON_VAL = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_wr,
    input  logic               take_rd,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [N_SLOTS-1:0] req_hit,
    input  logic               req_miss,
    input  logic               pready,
    input  logic               pslverr,
    input  logic [DATA_W-1:0]  prdata,
    input  logic               bready,
    input  logic               rready,
    output logic               idle,
    output logic [N_SLOTS-1:0] psel,
    output logic               penable,
    output logic [ADDR_W-1:0]  paddr,
    output logic               pwrite,
    output logic [DATA_W-1:0]  pwdata,
    output logic               bvalid,
    output logic [1:0]         bresp,
    output logic               rvalid,
    output logic [1:0]         rresp,
    output logic [DATA_W-1:0]  rdata
);
    seq_state_e          state_q;
    txn_tag_t            tag_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [N_SLOTS-1:0]  sel_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [DATA_W-1:0]   err_data;
    logic [DATA_W-1:0]   miss_data;
    logic                taken;
    logic                resp_done;

    if (POISON_EN) begin : g_poison
        assign err_data  = POISON_VAL;
        assign miss_data = POISON_VAL;
    end else begin : g_pass
        assign err_data  = prdata;
        assign miss_data = '0;
    end

    assign taken     = take_wr || take_rd;
    assign resp_done = tag_q.wr ? bready : rready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (taken) begin
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    sel_q    <= req_hit;
                    tag_q.wr <= take_wr;
                    if (req_miss) begin
                        tag_q.code <= pick_resp(1'b1, 1'b0);
                        rdata_q    <= miss_data;
                        state_q    <= ST_RESP;
                    end else begin
                        state_q    <= ST_SETUP;
                    end
                end
                ST_SETUP:  state_q <= ST_ACCESS;
                ST_ACCESS: if (pready) begin
                    tag_q.code <= pick_resp(1'b0, pslverr);
                    rdata_q    <= pslverr ? err_data : prdata;
                    state_q    <= ST_RESP;
                end
                ST_RESP:   if (resp_done) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign psel    = (state_q == ST_SETUP || state_q == ST_ACCESS) ? sel_q : '0;
    assign penable = (state_q == ST_ACCESS);
    assign paddr   = addr_q;
    assign pwrite  = tag_q.wr;
    assign pwdata  = wdata_q;
    assign bvalid  = (state_q == ST_RESP) &&  tag_q.wr;
    assign rvalid  = (state_q == ST_RESP) && !tag_q.wr;
    assign bresp   = tag_q.code;
    assign rresp   = tag_q.code;
    assign rdata   = rdata_q;
endmodule

// File: rtl/axil_apb_bridge.sv
module axil_apb_bridge
    import axil_apb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int N_SLOTS = 4,
    parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BASE =
        {32'h0000_4000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
    parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_SIZE =
        {32'h0000_2000, 32'h0000_0800, 32'h0000_1000, 32'h0000_1000},
    parameter bit POISON_EN = 1'b1,
    parameter logic [DATA_W-1:0] POISON_VAL = 32'hDEAD_BEEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic [N_SLOTS-1:0] m_psel,
    output logic               m_penable,
    output logic [ADDR_W-1:0]  m_paddr,
    output logic               m_pwrite,
    output logic [DATA_W-1:0]  m_pwdata,
    input  logic [DATA_W-1:0]  m_prdata,
    input  logic               m_pready,
    input  logic               m_pslverr
);
    logic               idle;
    logic               take_wr;
    logic               take_rd;
    logic [ADDR_W-1:0]  req_addr;
    logic [N_SLOTS-1:0] req_hit;
    logic               req_miss;

    axil_apb_arb u_arb (
        .idle    (idle),
        .awvalid (s_awvalid),
        .wvalid  (s_wvalid),
        .arvalid (s_arvalid),
        .take_wr (take_wr),
        .take_rd (take_rd)
    );

    assign req_addr  = take_wr ? s_awaddr : s_araddr;
    assign s_awready = take_wr;
    assign s_wready  = take_wr;
    assign s_arready = take_rd;

    axil_apb_decode #(
        .ADDR_W    (ADDR_W),
        .N_SLOTS   (N_SLOTS),
        .SLOT_BASE (SLOT_BASE),
        .SLOT_SIZE (SLOT_SIZE)
    ) u_dec (
        .addr (req_addr),
        .hit  (req_hit),
        .miss (req_miss)
    );

    axil_apb_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .N_SLOTS    (N_SLOTS),
        .POISON_EN  (POISON_EN),
        .POISON_VAL (POISON_VAL)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .take_wr   (take_wr),
        .take_rd   (take_rd),
        .req_addr  (req_addr),
        .req_wdata (s_wdata),
        .req_hit   (req_hit),
        .req_miss  (req_miss),
        .pready    (m_pready),
        .pslverr   (m_pslverr),
        .prdata    (m_prdata),
        .bready    (s_bready),
        .rready    (s_rready),
        .idle      (idle),
        .psel      (m_psel),
        .penable   (m_penable),
        .paddr     (m_paddr),
        .pwrite    (m_pwrite),
        .pwdata    (m_pwdata),
        .bvalid    (s_bvalid),
        .bresp     (s_bresp),
        .rvalid    (s_rvalid),
        .rresp     (s_rresp),
        .rdata     (s_rdata)
    );
endmodule

// File: rtl/axil_apb_bridge_chk.sv
module axil_apb_bridge_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               s_awvalid,
    input logic               s_awready,
    input logic               s_wvalid,
    input logic               s_wready,
    input logic               s_arvalid,
    input logic               s_arready,
    input logic [1:0]         s_bresp,
    input logic               s_bvalid,
    input logic               s_bready,
    input logic [DATA_W-1:0]  s_rdata,
    input logic [1:0]         s_rresp,
    input logic               s_rvalid,
    input logic               s_rready,
    input logic [N_SLOTS-1:0] m_psel,
    input logic               m_penable,
    input logic [ADDR_W-1:0]  m_paddr,
    input logic               m_pwrite,
    input logic               m_pready,
    input logic               m_pslverr
);
    logic fin;
    assign fin = m_penable && m_pready;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_psel)); // R2
    AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (|m_psel && !m_penable) |=> (m_penable && m_psel == $past(m_psel))); // R2
    AST_ENABLE_HAS_SELECT: assert property (@(posedge clk) disable iff (rst)
        m_penable |-> |m_psel); // R2
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (m_penable && !m_pready) |=> (m_penable && $stable(m_paddr) && $stable(m_psel))); // R5
    AST_OKAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fin && !m_pslverr && m_pwrite) |=> (s_bvalid && s_bresp == 2'b00)); // R3
    AST_OKAY_READ: assert property (@(posedge clk) disable iff (rst)
        (fin && !m_pslverr && !m_pwrite) |=> (s_rvalid && s_rresp == 2'b00)); // R3
    AST_SLVERR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fin && m_pslverr && m_pwrite) |=> (s_bvalid && s_bresp == 2'b10)); // R4
    AST_SLVERR_READ: assert property (@(posedge clk) disable iff (rst)
        (fin && m_pslverr && !m_pwrite) |=> (s_rvalid && s_rresp == 2'b10)); // R4
    AST_B_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R7
    AST_R_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rresp) && $stable(s_rdata))); // R7
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid || s_rvalid || |m_psel) |-> !(s_awready || s_arready)); // R10
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        !(s_bvalid && s_rvalid)); // R10
    AST_WRITE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        s_awready |-> (s_awvalid && s_wvalid && s_wready)); // R11
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        s_arready |-> !(s_awvalid && s_wvalid)); // R8
endmodule

bind axil_apb_bridge axil_apb_bridge_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_SLOTS (N_SLOTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_bresp   (s_bresp),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .m_psel    (m_psel),
    .m_penable (m_penable),
    .m_paddr   (m_paddr),
    .m_pwrite  (m_pwrite),
    .m_pready  (m_pready),
    .m_pslverr (m_pslverr)
);

// File: tb/axil_apb_bridge_bench.sv
`timescale 1ns/1ps
module axil_apb_bridge_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NS = 4;
    localparam logic [NS*AW-1:0] BASES = {32'h4000, 32'h2000, 32'h1000, 32'h0000};
    localparam logic [NS*AW-1:0] SIZES = {32'h2000, 32'h0800, 32'h1000, 32'h1000};
    localparam logic [DW-1:0]    POISON = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic          awvalid = 0, wvalid = 0, arvalid = 0, bready = 0, rready = 0;
    logic [DW-1:0] wdata = '0;
    logic          awready, wready, arready, bvalid, rvalid;
    logic [1:0]    bresp, rresp;
    logic [DW-1:0] rdata;
    logic [NS-1:0] psel;
    logic          penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic [DW-1:0] prdata = '0;
    logic          pready = 0, pslverr = 0;

    axil_apb_bridge #(
        .ADDR_W(AW), .DATA_W(DW), .N_SLOTS(NS),
        .SLOT_BASE(BASES), .SLOT_SIZE(SIZES),
        .POISON_EN(1'b1), .POISON_VAL(POISON)
    ) u_axil_apb_bridge (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .m_psel(psel), .m_penable(penable), .m_paddr(paddr), .m_pwrite(pwrite),
        .m_pwdata(pwdata), .m_prdata(prdata), .m_pready(pready), .m_pslverr(pslverr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // peripheral model: shows inverted error/data while not completing (R5)
    int            cfg_wait = 0;
    logic          cfg_err = 0;
    logic [DW-1:0] cfg_rdata = '0;
    int            cnt = 0;
    always @(negedge clk) begin
        if (|psel && !penable) begin
            cnt    = cfg_wait;
            pready = 1'b0;
        end else if (penable) begin
            pready = (cnt == 0);
            if (cnt > 0) cnt = cnt - 1;
        end else begin
            pready = 1'b0;
        end
        pslverr = pready ? cfg_err : !cfg_err;
        prdata  = pready ? cfg_rdata : ~cfg_rdata;
    end

    // APB monitor
    int            sel_cycles = 0;
    logic [NS-1:0] seen_sel = '0;
    logic [AW-1:0] seen_addr = '0;
    logic          seen_wr = 0;
    logic [DW-1:0] seen_wdata = '0;
    always @(posedge clk) begin
        if (|psel) begin
            sel_cycles++;
            seen_sel = seen_sel | psel;
            if (!penable) begin
                seen_addr  = paddr;
                seen_wr    = pwrite;
                seen_wdata = pwdata;
            end
        end
    end

    function automatic int exp_slot(input logic [AW-1:0] a);
        for (int i = 0; i < NS; i++) begin
            if ({1'b0, a} >= {1'b0, BASES[i*AW +: AW]} &&
                {1'b0, a} < {1'b0, BASES[i*AW +: AW]} + {1'b0, SIZES[i*AW +: AW]})
                return i;
        end
        return -1;
    endfunction

    function automatic logic [1:0] exp_code(input logic miss, input logic err);
        return miss ? 2'b11 : (err ? 2'b10 : 2'b00);
    endfunction

    task automatic run_txn(input bit is_w, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                           input int wt, input bit err, input logic [DW-1:0] rd, input int hold);
        int            slot;
        logic [1:0]    code;
        logic [DW-1:0] exp_rd;
        slot = exp_slot(addr);
        code = exp_code(slot < 0, err);
        exp_rd = (code == 2'b00) ? rd : POISON;
        cfg_wait = wt; cfg_err = err; cfg_rdata = rd;
        @(negedge clk);
        sel_cycles = 0; seen_sel = '0;
        if (is_w) begin
            awaddr = addr; wdata = data; awvalid = 1; wvalid = 1;
        end else begin
            araddr = addr; arvalid = 1;
        end
        #1;
        while (!(is_w ? awready : arready)) begin @(negedge clk); #1; end
        if (is_w) check(wready == awready, "R11 wready with awready", wready, awready);
        @(negedge clk);
        awvalid = 0; wvalid = 0; arvalid = 0;
        while (!(is_w ? bvalid : rvalid)) @(negedge clk);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(is_w ? bvalid : rvalid, "R7 valid held until ready", 0, 1);
        end
        if (is_w) begin
            check(bresp == code, (code == 2'b11) ? "R6 bresp decerr" :
                                 (err ? "R4 bresp slverr" : "R3 bresp okay"), bresp, code);
            check(!rvalid, "R10 no read response on a write", rvalid, 0);
            bready = 1;
        end else begin
            check(rresp == code, (code == 2'b11) ? "R6 rresp decerr" :
                                 (err ? "R4 rresp slverr" : "R3 rresp okay"), rresp, code);
            check(rdata == exp_rd, "R9 read data policy", rdata, exp_rd);
            rready = 1;
        end
        @(negedge clk);
        bready = 0; rready = 0;
        check(!(bvalid || rvalid), "R7 valid drops after handshake", {bvalid, rvalid}, 0);
        if (slot < 0) begin
            check(sel_cycles == 0, "R6 no select on decode miss", sel_cycles, 0);
        end else begin
            check(seen_sel == NS'(1 << slot), "R2 decoded select", seen_sel, 1 << slot);
            check(sel_cycles == 2 + wt, "R5 wait states extend transfer", sel_cycles, 2 + wt);
            check(seen_addr == addr && seen_wr == is_w, "R2 address and direction",
                  {seen_wr, seen_addr}, {is_w, addr});
            if (is_w) check(seen_wdata == data, "R2 write data", seen_wdata, data);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BAD_5EED));
        repeat (3) @(negedge clk);
        check(!bvalid && !rvalid && psel == 0 && !penable, "R1 quiet during reset",
              {bvalid, rvalid, psel, penable}, 0);
        rst = 0;
        @(negedge clk);
        check(!bvalid && !rvalid && psel == 0 && !penable, "R1 quiet after reset",
              {bvalid, rvalid, psel, penable}, 0);

        // directed corner cases
        run_txn(1, 32'h0000_0010, 32'h1234_5678, 0, 0, '0, 0);           // R3 okay write
        run_txn(0, 32'h0000_1004, '0, 2, 0, 32'hCAFE_0001, 1);           // R3 read, R5 waits
        run_txn(1, 32'h0000_27FC, 32'hA5A5_A5A5, 1, 1, '0, 2);           // R4 write error at top of window
        run_txn(0, 32'h0000_5FFC, '0, 3, 1, 32'h1111_2222, 0);           // R4 read error, R9 poison
        run_txn(1, 32'h0000_2800, 32'h5555_AAAA, 0, 1, '0, 1);           // R6 miss beats error
        run_txn(0, 32'h0000_6000, '0, 0, 1, 32'h7777_7777, 2);           // R6 read miss, R9
        run_txn(0, 32'h0000_4000, '0, 0, 0, 32'h0BAD_F00D, 0);           // R5 error garbage ignored

        // R8: write and read offered together, write wins
        cfg_wait = 1; cfg_err = 0; cfg_rdata = 32'h2468_ACE0;
        @(negedge clk);
        awaddr = 32'h0000_0100; wdata = 32'h0F0F_0F0F; awvalid = 1; wvalid = 1;
        araddr = 32'h0000_1100; arvalid = 1;
        #1;
        check(awready && !arready, "R8 write accepted first", {awready, arready}, 2'b10);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        while (!bvalid) begin
            check(!arready && !rvalid, "R10 read held off while busy", {arready, rvalid}, 0);
            @(negedge clk);
        end
        check(bresp == 2'b00, "R8 write response first", bresp, 0);
        bready = 1;
        @(negedge clk);
        bready = 0;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        check(rresp == 2'b00 && rdata == 32'h2468_ACE0, "R8 read served after write",
              {rresp, rdata}, {2'b00, 32'h2468_ACE0});
        rready = 1;
        @(negedge clk);
        rready = 0;

        // constrained random traffic
        for (int n = 0; n < 80; n++) begin
            int            r;
            logic [AW-1:0] a;
            r = int'($urandom % 6);
            case (r)
                0: a = 32'h0000 + (($urandom % 32'h400) << 2);
                1: a = 32'h1000 + (($urandom % 32'h400) << 2);
                2: a = 32'h2000 + (($urandom % 32'h200) << 2);
                3: a = 32'h4000 + (($urandom % 32'h800) << 2);
                4: a = 32'h2800 + (($urandom % 32'h600) << 2);
                default: a = 32'h6000 + (($urandom % 32'h1000) << 2);
            endcase
            run_txn(bit'($urandom % 2), a, $urandom, int'($urandom % 4),
                    bit'($urandom % 3 == 0), $urandom, int'($urandom % 3));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule